// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a clock synthesizer against a frequency change that leaves the system hung. When its enable input is high, every accepted frequency change starts a countdown. The timeout is a 5-bit count multiplied by a unit of time. The unit is built from a 1 ms tick input by a prescale divider, and a select input picks a short or a long unit (150 or 2500 ticks by default). If the countdown runs out, the block sets a sticky timeout status. If its watchdog reset enable is high, it also drives an active-low system reset pulse. It then enters a recovery lock, in which it reports which fallback frequency source must be used and refuses every further frequency change request.

Software leaves the recovery lock by driving the enable input low. The same action also stops a countdown in progress and reloads the timeout value. A separate enable makes any accepted frequency change emit the same reset pulse. The status bit is cleared only by a status write whose data bit is 1. The register file that holds the control fields, their power-on values and the frequency synthesizer itself sit outside this block.

Top module: `fcw_guard`

## Requirements
- R1: After reset, timeout status is 0, the reset output `sys_rst_n_o` is 1, the lock flag is 0 and `rcv_sel_o` is 2'b00.
- R2: When a frequency change is accepted while `wd_en_i` is 1, the status rises on the tick that completes max(N,1)×U ticks counted after the change. N is `tmo_count_i` and U is UNIT_SHORT_TICKS when `unit_long_i` is 0, or UNIT_LONG_TICKS when it is 1. The status stays 0 before that tick.
- R3: With `wd_en_i` at 0, a frequency change starts no countdown, and the status stays 0 for any number of ticks.
- R4: Driving `wd_en_i` to 0 stops a countdown and reloads the timeout. A countdown only resumes after a new accepted change. A new accepted change during a countdown restarts the full timeout.
- R5: The status is sticky. A status write with data 1 clears it, and a status write with data 0 leaves it unchanged.
- R6: On expiry with `rst_on_tmo_i` at 1, `sys_rst_n_o` goes low from the expiry and stays low for exactly PULSE_TICKS ticks. With `rst_on_tmo_i` at 0, it stays high.
- R7: An accepted frequency change with `rst_on_chg_i` at 1 produces the same PULSE_TICKS-tick low pulse, whatever the value of `wd_en_i`.
- R8: On expiry the lock flag goes to 1. `rcv_sel_o` shows the source sampled from `rcv_src_i` at expiry: 2'b01 for the strap setting (`rcv_src_i`=0) and 2'b10 for the programmed N/M values (`rcv_src_i`=1). Later changes of `rcv_src_i` do not alter it while locked.
- R9: `freq_chg_grant_o` equals `freq_chg_i` in the same cycle when unlocked and is 0 while locked. A refused change starts no countdown and no reset pulse.
- R10: One cycle of `wd_en_i` at 0 releases the lock and returns `rcv_sel_o` to 2'b00, while the status keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| wd_en_i | input | 1 | Watchdog enable; low stops, reloads and unlocks |
| tmo_count_i | input | COUNT_W | Timeout in units |
| unit_long_i | input | 1 | Unit select: 0 short, 1 long |
| rst_on_tmo_i | input | 1 | Emit reset pulse on expiry |
| rst_on_chg_i | input | 1 | Emit reset pulse on accepted frequency change |
| status_wr_i | input | 1 | Status write strobe |
| status_wdata_i | input | 1 | Status write data; 1 clears |
| freq_chg_i | input | 1 | Frequency change request pulse |
| rcv_src_i | input | 1 | Fallback source: 0 strap, 1 programmed N/M |
| freq_chg_grant_o | output | 1 | Request accepted this cycle |
| tmo_status_o | output | 1 | Sticky timeout status |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |
| rcv_lock_o | output | 1 | Recovery lock active |
| rcv_sel_o | output | 2 | Fallback in force: 00 none, 01 strap, 10 programmed |

## Verification
The bench builds the block with a short unit of 3 ticks, a long unit of 5 ticks and a 4-tick reset pulse, and keeps the 5-bit count width. With these values, every count value from 0 to 31 under both unit selects fits in one run, so the timeout formula is checked for all 64 settings, together with the reset-enable and fallback-source choices that alternate across the sweep. Directed sequences cover the order-dependent cases: a stop and reload in mid-count, a restart by a new change, refusal while locked, and release of the lock.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    typedef enum logic [1:0] {
        RCV_NONE  = 2'b00,
        RCV_STRAP = 2'b01,
        RCV_PROG  = 2'b10
    } rcv_sel_e;

    typedef struct packed {
        logic     run;
        logic     status;
        logic     lock;
        rcv_sel_e sel;
    } guard_state_t;

endpackage

// File: rtl/fcw_prescale.sv
module fcw_prescale #(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    input  logic long_i,
    output logic unit_done_o
);
    localparam int MAXT = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
    localparam int PW   = $clog2(MAXT + 1);
    localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_TICKS - 1);
    localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_TICKS - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PW-1:0] last;
    logic          at_last;

    always_comb begin
        s_d         = s_q;
        last        = long_i ? LONG_LAST : SHORT_LAST;
        at_last     = (s_q.cnt >= last);
        unit_done_o = 1'b0;
        if (clear_i) begin
            s_d.cnt = '0;
        end else if (run_i && tick_i) begin
            if (at_last) begin
                s_d.cnt     = '0;
                unit_done_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < PW'(MAXT));

    // R4
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> s_q.cnt == '0);

endmodule

// File: rtl/fcw_down.sv
module fcw_down #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          step_i,
    output logic          expire_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } down_state_t;

    down_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (load_i) begin
            s_d.cnt = load_val_i;
        end else if (step_i) begin
            if (s_q.cnt <= CW'(1)) expire_o = 1'b1;
            else                   s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // R2
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && s_q.cnt > CW'(1)) |=> s_q.cnt == $past(s_q.cnt) - 1'b1);

endmodule

// File: rtl/fcw_pulse.sv
module fcw_pulse #(
    parameter int PULSE_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o
);
    localparam int QW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [QW-1:0] left;
    } pulse_state_t;

    pulse_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i)                         s_d.left = QW'(PULSE_TICKS);
        else if (tick_i && s_q.left != '0)   s_d.left = s_q.left - 1'b1;
        active_o = (s_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(start_i));

endmodule

// File: rtl/fcw_guard.sv
module fcw_guard #(
    parameter int UNIT_SHORT_TICKS = 150,
    parameter int UNIT_LONG_TICKS  = 2500,
    parameter int COUNT_W          = 5,
    parameter int PULSE_TICKS      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wd_en_i,
    input  logic [COUNT_W-1:0] tmo_count_i,
    input  logic               unit_long_i,
    input  logic               rst_on_tmo_i,
    input  logic               rst_on_chg_i,
    input  logic               status_wr_i,
    input  logic               status_wdata_i,
    input  logic               freq_chg_i,
    input  logic               rcv_src_i,
    output logic               freq_chg_grant_o,
    output logic               tmo_status_o,
    output logic               sys_rst_n_o,
    output logic               rcv_lock_o,
    output logic [1:0]         rcv_sel_o
);
    import fcw_pkg::*;

    guard_state_t s_d, s_q;
    logic accept, reload, unit_done, expire, pulse_start, pulse_on;

    assign accept      = freq_chg_i & ~s_q.lock;
    assign reload      = ~wd_en_i | accept;
    assign pulse_start = (expire & rst_on_tmo_i) | (accept & rst_on_chg_i);

    fcw_prescale #(
        .SHORT_TICKS (UNIT_SHORT_TICKS),
        .LONG_TICKS  (UNIT_LONG_TICKS)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (reload),
        .run_i       (s_q.run),
        .tick_i      (tick_i),
        .long_i      (unit_long_i),
        .unit_done_o (unit_done)
    );

    fcw_down #(
        .CW (COUNT_W)
    ) u_down (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (reload),
        .load_val_i (tmo_count_i),
        .step_i     (unit_done),
        .expire_o   (expire)
    );

    fcw_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (pulse_start),
        .tick_i   (tick_i),
        .active_o (pulse_on)
    );

    always_comb begin
        s_d = s_q;
        if (!wd_en_i) begin
            s_d.run  = 1'b0;
            s_d.lock = 1'b0;
            s_d.sel  = RCV_NONE;
        end else begin
            if (accept) s_d.run = 1'b1;
            if (expire) begin
                s_d.run  = 1'b0;
                s_d.lock = 1'b1;
                s_d.sel  = rcv_src_i ? RCV_PROG : RCV_STRAP;
            end
        end
        if (status_wr_i && status_wdata_i) s_d.status = 1'b0;
        if (expire)                        s_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{run: 1'b0, status: 1'b0, lock: 1'b0, sel: RCV_NONE};
        else        s_q <= s_d;
    end

    assign freq_chg_grant_o = accept;
    assign tmo_status_o     = s_q.status;
    assign sys_rst_n_o      = ~pulse_on;
    assign rcv_lock_o       = s_q.lock;
    assign rcv_sel_o        = s_q.sel;

    // R2
    expire_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tmo_status_o);

    // R8
    lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_lock_o && wd_en_i) |=> rcv_lock_o);

    // R8
    lock_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_lock_o |-> (rcv_sel_o == 2'b01 || rcv_sel_o == 2'b10));

    // R8
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_lock_o && $past(rcv_lock_o)) |-> $stable(rcv_sel_o));

    // R9
    locked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_lock_o && wd_en_i) |=> !s_q.run);

    // R10
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_i |=> (!rcv_lock_o && rcv_sel_o == 2'b00));

endmodule

// File: tb/tb_fcw_guard.sv
`timescale 1ns/100ps
module tb_fcw_guard;
    localparam int SH = 3;
    localparam int LG = 5;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, en = 0, ulong = 0, rtmo = 0, rchg = 0;
    logic swr = 0, swd = 0, chg = 0, src = 0;
    logic [4:0] cnt = 5'd0;
    logic grant, status, rstn_o, lock;
    logic [1:0] sel;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fcw_guard #(
        .UNIT_SHORT_TICKS (SH),
        .UNIT_LONG_TICKS  (LG),
        .COUNT_W          (5),
        .PULSE_TICKS      (PL)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .tick_i           (tick),
        .wd_en_i          (en),
        .tmo_count_i      (cnt),
        .unit_long_i      (ulong),
        .rst_on_tmo_i     (rtmo),
        .rst_on_chg_i     (rchg),
        .status_wr_i      (swr),
        .status_wdata_i   (swd),
        .freq_chg_i       (chg),
        .rcv_src_i        (src),
        .freq_chg_grant_o (grant),
        .tmo_status_o     (status),
        .sys_rst_n_o      (rstn_o),
        .rcv_lock_o       (lock),
        .rcv_sel_o        (sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_chg();
        chg = 1'b1; @(negedge clk);
        chg = 1'b0;
    endtask

    task automatic status_write(input logic d);
        swr = 1'b1; swd = d; @(negedge clk);
        swr = 1'b0; swd = 1'b0;
    endtask

    task automatic unlock();
        en = 1'b0; @(negedge clk);
        en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int early, lows, exp_t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 rst_n", rstn_o, 1);
        chk("R1 lock", lock, 0);
        chk("R1 sel", sel, 0);

        // R3 disabled: no countdown; R9 grant when unlocked
        cnt = 5'd1; ulong = 0;
        chg = 1'b1; #1;
        chk("R9 grant unlocked", grant, 1);
        @(negedge clk); chg = 1'b0;
        ticks(10);
        chk("R3 no countdown when disabled", status, 0);

        // R7 reset pulse on change
        rchg = 1'b1;
        pulse_chg();
        chk("R7 pulse starts", rstn_o, 0);
        ticks(PL - 1);
        chk("R7 pulse still low", rstn_o, 0);
        ticks(1);
        chk("R7 pulse ends", rstn_o, 1);
        rchg = 1'b0;

        // R4 stop and reload
        en = 1'b1; cnt = 5'd2; ulong = 0; src = 1'b1;
        pulse_chg();
        ticks(4);
        en = 1'b0; @(negedge clk); en = 1'b1;
        ticks(10);
        chk("R4 stopped after disable", status, 0);
        pulse_chg();
        ticks(5);
        chk("R4 full reload early", status, 0);
        ticks(1);
        chk("R4 full reload expiry", status, 1);
        chk("R8 lock set", lock, 1);
        chk("R8 sel programmed", sel, 2);

        // R5 write 0 ignored
        status_write(1'b0);
        chk("R5 write0 ignored", status, 1);
        // R8 source change while locked
        src = 1'b0; @(negedge clk);
        chk("R8 sel held", sel, 2);
        // R10 release
        en = 1'b0; @(negedge clk);
        chk("R10 lock released", lock, 0);
        chk("R10 sel none", sel, 0);
        chk("R10 status kept", status, 1);
        en = 1'b1;
        // R5 write 1 clears
        status_write(1'b1);
        chk("R5 write1 clears", status, 0);

        // R4 restart on new change
        pulse_chg();
        ticks(4);
        pulse_chg();
        ticks(5);
        chk("R4 restart early", status, 0);
        ticks(1);
        chk("R4 restart expiry", status, 1);
        chk("R8 sel strap", sel, 1);

        // R9 refused while locked
        rchg = 1'b1;
        chg = 1'b1; #1;
        chk("R9 grant refused", grant, 0);
        @(negedge clk); chg = 1'b0;
        chk("R9 no pulse on refused", rstn_o, 1);
        status_write(1'b1);
        ticks(20);
        chk("R9 no countdown when locked", status, 0);
        chk("R9 no pulse later", rstn_o, 1);
        rchg = 1'b0;

        // R2 R6 R8 sweep over all counts and both units
        for (int u = 0; u < 2; u++) begin
            for (int n = 0; n < 32; n++) begin
                cnt = 5'(n); ulong = u[0];
                rtmo = n[0]; src = n[1];
                unlock();
                status_write(1'b1);
                pulse_chg();
                exp_t = ((n == 0) ? 1 : n) * (u ? LG : SH);
                early = 0;
                for (int k = 0; k < exp_t - 1; k++) begin
                    ticks(1);
                    if (status) early = 1;
                end
                chk($sformatf("R2 early n=%0d u=%0d", n, u), early, 0);
                ticks(1);
                chk($sformatf("R2 expiry n=%0d u=%0d", n, u), status, 1);
                chk("R8 lock after expiry", lock, 1);
                chk("R8 sel after expiry", sel, n[1] ? 2 : 1);
                chk("R6 reset on expiry", rstn_o, n[0] ? 0 : 1);
                if (n[0]) begin
                    lows = 0;
                    for (int k = 0; k < PL - 1; k++) begin
                        ticks(1);
                        if (!rstn_o) lows++;
                    end
                    chk("R6 pulse low span", lows, PL - 1);
                    ticks(1);
                    chk("R6 pulse end", rstn_o, 1);
                end
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule